// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the condition flags that follow an ALU operation and keeps them in a flags register. It takes the two operands, the result the ALU produced, the class of the operation (addition, subtraction or bitwise logic) and a width select that picks byte or word operands. From these it computes carry or borrow, the nibble carry between bit 3 and bit 4, low-byte parity, zero, sign and signed overflow, and it registers them on the next clock edge when flag update is enabled.

The same register holds three control flags: string direction, interrupt enable and single-step trap. A dedicated command port sets or clears them one at a time. Arithmetic and logic updates never touch them. The ALU datapath and the instruction decode sit outside. The decoder drives the update enable and the command port, and the ALU drives the operands and the result.

Top module: `flag_unit`

## Requirements
- R1: The carry flag takes the carry out of the top bit of the selected width on add (op class 0), and on subtract (op class 1) it takes the borrow into that bit, which is set when the unsigned minuend is below the subtrahend. Width select 0 means bit 7, and 1 means bit 15.
- R2: On add and subtract, the auxiliary flag records the carry or borrow that passes from bit 3 into bit 4.
- R3: When flags are updated, parity is 1 if result bits 7..0 hold an even number of ones and 0 if they hold an odd number. This holds at both widths.
- R4: The zero flag is 1 exactly when the result bits inside the selected width are all 0. In byte mode, result bits 15..8 have no effect.
- R5: The sign flag copies result bit 7 in byte mode and result bit 15 in word mode.
- R6: On add, overflow is set when both operands have the same top bit and the result's top bit differs from it. On subtract, it is set when the operands' top bits differ and the result's top bit differs from the first operand's.
- R7: The logic class (op class 2) clears carry and overflow, keeps the auxiliary flag, and updates parity, zero and sign.
- R8: When update enable is 0, or the op class is 3, the six arithmetic flags keep their values.
- R9: A command with valid high loads the command value into one control flag. Selector 0 picks direction, 1 picks interrupt enable, 2 picks trap, and selector 3 changes nothing. Without a valid command the control flags hold.
- R10: Arithmetic flag updates never change the control flags.
- R11: A synchronous active-high reset clears all nine flags.
- R12: Flags are registered, so an update presented before a clock edge becomes visible just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Write arithmetic flags this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 no flag write |
| wide | input | 1 | 0 byte operands, 1 word operands |
| opa | input | 16 | First operand (minuend on subtract) |
| opb | input | 16 | Second operand (subtrahend on subtract) |
| res | input | 16 | ALU result |
| ctl_valid | input | 1 | Control flag command strobe |
| ctl_sel | input | 2 | Control flag selector |
| ctl_val | input | 1 | Value loaded into the selected control flag |
| fl_carry | output | 1 | Carry / borrow |
| fl_aux | output | 1 | Nibble carry / borrow |
| fl_parity | output | 1 | Even parity of result low byte |
| fl_zero | output | 1 | Result is zero |
| fl_sign | output | 1 | Result top bit |
| fl_ovf | output | 1 | Signed overflow |
| fl_dir | output | 1 | String direction control flag |
| fl_ien | output | 1 | Interrupt enable control flag |
| fl_trap | output | 1 | Single-step trap control flag |

## Verification
The carry, borrow, nibble and overflow rules are recovered from the operand and result bits. They therefore assume that the result input really is the sum, difference or bitwise combination of the operands. The bench always builds the result arithmetically from the operands it drives, and it adds unrelated upper bits only in byte mode, where they must be ignored. The checker also assumes that the command and update inputs stay steady over a clock edge. The bench drives every input on the falling edge.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_HOLD  = 2'd3
  } opc_e;

  typedef enum logic [1:0] {
    CF_DIR  = 2'd0,
    CF_IEN  = 2'd1,
    CF_TRAP = 2'd2,
    CF_NONE = 2'd3
  } cfsel_e;

  typedef struct packed {
    logic c;
    logic a;
    logic p;
    logic z;
    logic s;
    logic o;
  } aflags_t;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trap;
  } cflags_t;

endpackage

// File: rtl/flag_eval.sv
module flag_eval
  import flag_unit_pkg::*;
#(
  parameter int DW  = 16,
  parameter int BW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] res,
  input  logic          wide,
  input  opc_e          opc,
  input  logic          aux_prev,
  output aflags_t       nxt,
  output logic          writes
);

  localparam int NW = 2;

  logic [NW-1:0] w_c, w_o, w_s, w_z;

  // Carry, overflow, sign and zero for each supported width.
  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam int W   = (g == 0) ? BW : DW;
    localparam int MSB = W - 1;
    logic am, bm, rm, cin;
    assign am  = opa[MSB];
    assign bm  = opb[MSB];
    assign rm  = res[MSB];
    assign cin = am ^ bm ^ rm;
    always_comb begin
      w_s[g] = rm;
      w_z[g] = ~|res[MSB:0];
      if (opc == OPC_SUB) begin
        w_c[g] = (~am & bm) | (~(am ^ bm) & cin);
        w_o[g] = (am != bm) && (rm != am);
      end else begin
        w_c[g] = (am & bm) | ((am ^ bm) & cin);
        w_o[g] = (am == bm) && (rm != am);
      end
    end
  end

  logic sel;
  logic nib_cross;
  assign sel       = wide;
  assign nib_cross = opa[NIB] ^ opb[NIB] ^ res[NIB];

  always_comb begin
    nxt.p  = ~^res[BW-1:0];
    nxt.z  = w_z[sel];
    nxt.s  = w_s[sel];
    writes = (opc != OPC_HOLD);
    if (opc == OPC_LOGIC) begin
      nxt.c = 1'b0;
      nxt.o = 1'b0;
      nxt.a = aux_prev;
    end else begin
      nxt.c = w_c[sel];
      nxt.o = w_o[sel];
      nxt.a = nib_cross;
    end
  end

endmodule

// File: rtl/flag_arith_reg.sv
module flag_arith_reg
  import flag_unit_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  aflags_t d,
  output aflags_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/flag_ctrl_reg.sv
module flag_ctrl_reg
  import flag_unit_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_v,
  input  cfsel_e  cmd_sel,
  input  logic    cmd_val,
  output cflags_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (cmd_v) begin
      case (cmd_sel)
        CF_DIR:  q.dir  <= cmd_val;
        CF_IEN:  q.ien  <= cmd_val;
        CF_TRAP: q.trap <= cmd_val;
        default: q      <= q;
      endcase
    end
  end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
#(
  parameter int DW  = 16,
  parameter int BW  = 8,
  parameter int NIB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [1:0]    op_class,
  input  logic          wide,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] res,
  input  logic          ctl_valid,
  input  logic [1:0]    ctl_sel,
  input  logic          ctl_val,
  output logic          fl_carry,
  output logic          fl_aux,
  output logic          fl_parity,
  output logic          fl_zero,
  output logic          fl_sign,
  output logic          fl_ovf,
  output logic          fl_dir,
  output logic          fl_ien,
  output logic          fl_trap
);

  aflags_t a_nxt, a_q;
  cflags_t c_q;
  logic    a_writes;

  flag_eval #(.DW(DW), .BW(BW), .NIB(NIB)) u_eval (
    .opa      (opa),
    .opb      (opb),
    .res      (res),
    .wide     (wide),
    .opc      (opc_e'(op_class)),
    .aux_prev (a_q.a),
    .nxt      (a_nxt),
    .writes   (a_writes)
  );

  flag_arith_reg u_areg (
    .clk (clk),
    .rst (rst),
    .we  (upd_en && a_writes),
    .d   (a_nxt),
    .q   (a_q)
  );

  flag_ctrl_reg u_creg (
    .clk     (clk),
    .rst     (rst),
    .cmd_v   (ctl_valid),
    .cmd_sel (cfsel_e'(ctl_sel)),
    .cmd_val (ctl_val),
    .q       (c_q)
  );

  assign fl_carry  = a_q.c;
  assign fl_aux    = a_q.a;
  assign fl_parity = a_q.p;
  assign fl_zero   = a_q.z;
  assign fl_sign   = a_q.s;
  assign fl_ovf    = a_q.o;
  assign fl_dir    = c_q.dir;
  assign fl_ien    = c_q.ien;
  assign fl_trap   = c_q.trap;

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_en,
  input logic [1:0]    op_class,
  input logic          wide,
  input logic [DW-1:0] res,
  input logic          ctl_valid,
  input logic          fl_carry,
  input logic          fl_aux,
  input logic          fl_parity,
  input logic          fl_zero,
  input logic          fl_sign,
  input logic          fl_ovf,
  input logic          fl_dir,
  input logic          fl_ien,
  input logic          fl_trap
);

  logic act;
  assign act = upd_en && (op_class != 2'd3);

  AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    act |=> (fl_parity == ~^$past(res[7:0]))); // R3

  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
    (act && wide && res == '0) |=> fl_zero); // R4

  AST_SIGN_WORD: assert property (@(posedge clk) disable iff (rst)
    (act && wide) |=> (fl_sign == $past(res[DW-1]))); // R5

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_class == 2'd2) |=> (!fl_carry && !fl_ovf && $stable(fl_aux))); // R7

  AST_NO_UPDATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !act |=> $stable({fl_carry, fl_aux, fl_parity, fl_zero, fl_sign, fl_ovf})); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl_valid |=> $stable({fl_dir, fl_ien, fl_trap})); // R10

endmodule

bind flag_unit flag_unit_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .upd_en    (upd_en),
  .op_class  (op_class),
  .wide      (wide),
  .res       (res),
  .ctl_valid (ctl_valid),
  .fl_carry  (fl_carry),
  .fl_aux    (fl_aux),
  .fl_parity (fl_parity),
  .fl_zero   (fl_zero),
  .fl_sign   (fl_sign),
  .fl_ovf    (fl_ovf),
  .fl_dir    (fl_dir),
  .fl_ien    (fl_ien),
  .fl_trap   (fl_trap)
);

// File: tb/flag_unit_bench.sv
module flag_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst;
  logic        upd_en;
  logic [1:0]  op_class;
  logic        wide;
  logic [15:0] opa, opb, res;
  logic        ctl_valid;
  logic [1:0]  ctl_sel;
  logic        ctl_val;
  logic        fl_carry, fl_aux, fl_parity, fl_zero, fl_sign, fl_ovf;
  logic        fl_dir, fl_ien, fl_trap;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [5:0] exp_a;
  logic [2:0] exp_c;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flag_unit u_flag_unit (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class), .wide(wide),
    .opa(opa), .opb(opb), .res(res),
    .ctl_valid(ctl_valid), .ctl_sel(ctl_sel), .ctl_val(ctl_val),
    .fl_carry(fl_carry), .fl_aux(fl_aux), .fl_parity(fl_parity), .fl_zero(fl_zero),
    .fl_sign(fl_sign), .fl_ovf(fl_ovf),
    .fl_dir(fl_dir), .fl_ien(fl_ien), .fl_trap(fl_trap)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] flags_now();
    return {fl_carry, fl_aux, fl_parity, fl_zero, fl_sign, fl_ovf, fl_dir, fl_ien, fl_trap};
  endfunction

  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  // Drive one operation on the falling edge, sample just after the next rising edge (R12).
  task automatic run_op(input string tag, input int opc, input bit w, input bit en,
                        input logic [15:0] a, input logic [15:0] b, input int lop);
    int width, mask, ua, ub, full, r, sa, sb, sr;
    logic [15:0] rdrv;
    logic c, ax, p, z, s, o;
    width = w ? 16 : 8;
    mask  = (1 << width) - 1;
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    c = 1'b0; ax = exp_a[4]; o = 1'b0;
    if (opc == 0) begin
      full = ua + ub;
      r    = full & mask;
      c    = full > mask;
      ax   = ((ua & 15) + (ub & 15)) > 15;
    end else if (opc == 1) begin
      r  = (ua - ub) & mask;
      c  = ua < ub;
      ax = (ua & 15) < (ub & 15);
    end else begin
      case (lop)
        0: r = ua & ub;
        1: r = ua | ub;
        default: r = ua ^ ub;
      endcase
    end
    sa = (ua >> (width - 1)) & 1;
    sb = (ub >> (width - 1)) & 1;
    sr = (r  >> (width - 1)) & 1;
    if (opc == 0) o = (sa == sb) && (sr != sa);
    if (opc == 1) o = (sa != sb) && (sr != sa);
    p = ~^r[7:0];
    z = (r == 0);
    s = sr[0];
    rdrv = r[15:0];
    if (!w) rdrv[15:8] = a[15:8] ^ b[15:8];
    @(negedge clk);
    upd_en = en; op_class = 2'(opc); wide = w; opa = a; opb = b; res = rdrv;
    @(posedge clk);
    #1;
    if (en && opc != 3) exp_a = {c, ax, p, z, s, o};
    check(tag, flags_now(), {exp_a, exp_c});
  endtask

  task automatic ctl_cmd(input string tag, input logic [1:0] sel, input logic v);
    @(negedge clk);
    upd_en = 1'b0; ctl_valid = 1'b1; ctl_sel = sel; ctl_val = v;
    @(posedge clk);
    #1;
    case (sel)
      2'd0: exp_c[2] = v;
      2'd1: exp_c[1] = v;
      2'd2: exp_c[0] = v;
      default: ;
    endcase
    check(tag, flags_now(), {exp_a, exp_c});
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; upd_en = 1'b0; op_class = 2'd0; wide = 1'b0;
    opa = '0; opb = '0; res = '0; ctl_valid = 1'b0; ctl_sel = 2'd0; ctl_val = 1'b0;
    exp_a = '0; exp_c = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset state", flags_now(), 9'b0);
    @(negedge clk);
    rst = 1'b0;

    // R9: control flag commands
    ctl_cmd("R9 set direction", 2'd0, 1'b1);
    ctl_cmd("R9 set interrupt enable", 2'd1, 1'b1);
    ctl_cmd("R9 set trap", 2'd2, 1'b1);
    ctl_cmd("R9 selector 3 ignored", 2'd3, 1'b0);
    ctl_cmd("R9 clear interrupt enable", 2'd1, 1'b0);

    // R1 R2 R3 R4 R5 R6 R10: byte add/sub sweep, control flags must stay put
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 3) begin
        logic [15:0] hi;
        hi = rnd16();
        run_op("R1 R2 R3 R4 R5 R6 R10 byte add", 0, 1'b0, 1'b1, {hi[7:0], 8'(a)}, {hi[15:8], 8'(b)}, 0);
        run_op("R1 R2 R3 R4 R5 R6 R10 byte sub", 1, 1'b0, 1'b1, {hi[15:8], 8'(a)}, {hi[7:0], 8'(b)}, 0);
      end
    end

    // R7: logic class after carries, aux must persist
    for (int i = 0; i < 3000; i++) begin
      run_op("R1 R2 prep add", 0, 1'b0, 1'b1, rnd16(), rnd16(), 0);
      run_op("R7 logic op", 2, i[0], 1'b1, rnd16(), rnd16(), i % 3);
    end

    // R8: disabled update and hold class
    for (int i = 0; i < 500; i++) begin
      run_op("R8 update disabled", i % 3, i[0], 1'b0, rnd16(), rnd16(), 0);
      run_op("R8 hold class", 3, i[1], 1'b1, rnd16(), rnd16(), 0);
      run_op("R2 R6 refresh", 1, 1'b0, 1'b1, rnd16(), rnd16(), 0);
    end

    // Word corners (R1 R4 R5 R6)
    run_op("R1 R4 word wrap to zero", 0, 1'b1, 1'b1, 16'hFFFF, 16'h0001, 0);
    run_op("R6 word positive overflow", 0, 1'b1, 1'b1, 16'h7FFF, 16'h0001, 0);
    run_op("R6 word sub overflow", 1, 1'b1, 1'b1, 16'h8000, 16'h0001, 0);
    run_op("R1 word borrow", 1, 1'b1, 1'b1, 16'h0000, 16'h0001, 0);
    run_op("R3 R5 word parity low byte only", 0, 1'b1, 1'b1, 16'h8100, 16'h0003, 0);

    // Word random sweep
    for (int i = 0; i < 6000; i++) begin
      run_op("R1 R2 R3 R4 R5 R6 word add", 0, 1'b1, 1'b1, rnd16(), rnd16(), 0);
      run_op("R1 R2 R3 R4 R5 R6 word sub", 1, 1'b1, 1'b1, rnd16(), rnd16(), 0);
    end

    ctl_cmd("R9 clear direction", 2'd0, 1'b0);
    ctl_cmd("R9 clear trap", 2'd2, 1'b0);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    exp_a = '0; exp_c = '0;
    check("R11 reset after activity", flags_now(), 9'b0);
    finish_run();
  end

endmodule